// File: doc/BRIEF.md
# Instruction Queue with Full-Write Policy

This block is a small first-in first-out buffer for 32-bit instruction words. It sits between a memory-mapped write port, driven by a bus master, and an execution unit that reads the words. The bus side offers a word with a request and sees a ready signal. The execution side takes words with a valid/ready handshake. A control register holds three things: a low-water event threshold, a level-held flush bit and a policy bit. The policy bit decides what happens when a word arrives while all entries are occupied.

In drop policy, a write to a full queue is thrown away and never stalls the bus. In stall policy, the bus ready is withheld, which gives the master wait states, until the execution side frees an entry. In both policies such a write raises a sticky overflow cause. The flush bit empties the queue and keeps it empty for as long as it stays set. Three error inputs (illegal opcode, illegal condition code, bus error) set the flush bit from hardware. The block reports its occupancy, and it raises a level event while the occupancy is strictly below the threshold.

Top module: `cmd_queue`

## Requirements
- R1: After reset the control register reads 0x0002_0000: threshold 0 in bits [2:0], flush bit 16 clear, policy bit 17 set (stall). A control write stores bits [2:0], 16 and 17, and all other bits read back as zero.
- R2: Words leave in the order they were accepted. `pop_valid` is high exactly when the queue holds at least one word and flush is off. `pop_data` shows the oldest word.
- R3: `used_cnt` equals the number of stored words, from 0 to 8. A push and a pop in the same cycle on a full queue are both accepted and leave the count at 8.
- R4: `level_evt` is high exactly when `used_cnt` is strictly less than the threshold in control bits [2:0].
- R5: With bit 17 = 0, `push_rdy` stays high. A push to a full queue with no pop in the same cycle is discarded.
- R6: With bit 17 = 1, `push_rdy` is low exactly when the queue is full, flush is off and `pop_ready` is low. A held write is stored in the first cycle that an entry frees.
- R7: A push to a full queue with no pop in the same cycle sets `ovf_cause` one cycle later, in either policy. It stays set until an `ovf_clr` pulse. If a set and a clear arrive in the same cycle, the set wins.
- R8: While control bit 16 is 1, `used_cnt` reads 0, `pop_valid` is low, `push_rdy` is high, pushes are discarded and no overflow is raised. After bit 16 returns to 0, the queue is empty.
- R9: Any of `err_opcode`, `err_cond`, `err_bus` sets control bit 16 at the next edge, even over a control write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 32 | Control register write value |
| cfg_rd_data | output | 32 | Control register contents |
| push_req | input | 1 | Bus master offers a word |
| push_data | input | 32 | Offered instruction word |
| push_rdy | output | 1 | Low while a write is held with wait states |
| pop_valid | output | 1 | A word is available to the execution unit |
| pop_data | output | 32 | Oldest stored word |
| pop_ready | input | 1 | Execution unit takes the word |
| used_cnt | output | 4 | Number of stored words |
| level_evt | output | 1 | Occupancy below threshold |
| ovf_cause | output | 1 | Sticky overflow cause |
| ovf_clr | input | 1 | Write-one-to-clear pulse for the overflow cause |
| err_opcode | input | 1 | Illegal opcode error cause |
| err_cond | input | 1 | Illegal condition code error cause |
| err_bus | input | 1 | Bus error cause |

## Verification
The bench targets the full-queue boundary in both policies.
- A design that refuses a simultaneous push and pop when full would lose a word or report the wrong count.
- A design that drops a held write in stall mode would skip a word in the output order.
- A design that stalls in drop mode would hold `push_rdy` low.

It sweeps every threshold against every occupancy. An off-by-one comparison would raise the event one entry late.

It holds flush over several cycles with traffic and fires each error input together with a control write. A design that let a push in during flush, kept the old pointers, or let the software write win over the error would show stale words or a clear flush bit.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int CFG_W       = 32;
    localparam int LVL_W       = 3;
    localparam int FLUSH_BIT   = 16;
    localparam int STALL_BIT   = 17;
    localparam logic [CFG_W-1:0] CFG_RESET = 32'h0002_0000;

    typedef struct packed {
        logic             stall;
        logic             flush;
        logic [LVL_W-1:0] lvl;
    } qctl_t;

    function automatic qctl_t cfg_unpack(input logic [CFG_W-1:0] w);
        qctl_t c;
        c.stall = w[STALL_BIT];
        c.flush = w[FLUSH_BIT];
        c.lvl   = w[LVL_W-1:0];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_pack(input qctl_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[STALL_BIT]   = c.stall;
        w[FLUSH_BIT]   = c.flush;
        w[LVL_W-1:0]   = c.lvl;
        return w;
    endfunction
endpackage

// File: rtl/iq_ctrl_reg.sv
module iq_ctrl_reg
    import iq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             err_any,
    output qctl_t            ctl
);
    // Reserved bits of the write value are intentionally discarded.
    logic unused_rsvd;
    assign unused_rsvd = ^{wr_data[CFG_W-1:STALL_BIT+1], wr_data[FLUSH_BIT-1:LVL_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= cfg_unpack(CFG_RESET);
        end else begin
            if (wr_en)
                ctl <= cfg_unpack(wr_data);
            // Hardware error causes force a flush and win over software.
            if (err_any)
                ctl.flush <= 1'b1;
        end
    end
endmodule

// File: rtl/iq_store.sv
module iq_store #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en && !flush)
            mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= ptr_inc(wr_ptr);
            if (rd_en) rd_ptr <= ptr_inc(rd_ptr);
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/iq_push_gate.sv
module iq_push_gate (
    input  logic clk,
    input  logic rst,
    input  logic push_req,
    input  logic full,
    input  logic pop_fire,
    input  logic flush,
    input  logic stall_mode,
    input  logic ovf_clr,
    output logic push_acc,
    output logic push_rdy,
    output logic ovf_cause
);
    logic blocked;
    logic ovf_set;

    // A full queue only takes a word if an entry drains in the same cycle.
    assign blocked  = full && !pop_fire;
    assign push_acc = push_req && !flush && !blocked;
    assign ovf_set  = push_req && !flush && blocked;
    assign push_rdy = flush || !stall_mode || !blocked;

    always_ff @(posedge clk) begin
        if (rst)
            ovf_cause <= 1'b0;
        else if (ovf_set)
            ovf_cause <= 1'b1;
        else if (ovf_clr)
            ovf_cause <= 1'b0;
    end
endmodule

// File: rtl/cmd_queue.sv
module cmd_queue
    import iq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    output logic [CFG_W-1:0] cfg_rd_data,
    input  logic             push_req,
    input  logic [DW-1:0]    push_data,
    output logic             push_rdy,
    output logic             pop_valid,
    output logic [DW-1:0]    pop_data,
    input  logic             pop_ready,
    output logic [CW-1:0]    used_cnt,
    output logic             level_evt,
    output logic             ovf_cause,
    input  logic             ovf_clr,
    input  logic             err_opcode,
    input  logic             err_cond,
    input  logic             err_bus
);
    qctl_t         ctl;
    logic [CW-1:0] cnt;
    logic          full, pop_fire, push_acc;

    iq_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .err_any (err_opcode | err_cond | err_bus),
        .ctl     (ctl)
    );

    iq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (ctl.flush),
        .wr_en   (push_acc),
        .wr_data (push_data),
        .rd_en   (pop_fire),
        .rd_data (pop_data),
        .count   (cnt)
    );

    iq_push_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .push_req   (push_req),
        .full       (full),
        .pop_fire   (pop_fire),
        .flush      (ctl.flush),
        .stall_mode (ctl.stall),
        .ovf_clr    (ovf_clr),
        .push_acc   (push_acc),
        .push_rdy   (push_rdy),
        .ovf_cause  (ovf_cause)
    );

    assign full        = (cnt == CW'(DEPTH));
    assign used_cnt    = ctl.flush ? '0 : cnt;
    assign pop_valid   = !ctl.flush && (cnt != '0);
    assign pop_fire    = pop_valid && pop_ready;
    assign level_evt   = used_cnt < CW'(ctl.lvl);
    assign cfg_rd_data = cfg_pack(ctl);
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [31:0]   cfg_rd_data,
    input logic          push_rdy,
    input logic          pop_valid,
    input logic          pop_ready,
    input logic [CW-1:0] used_cnt,
    input logic          ovf_cause,
    input logic          ovf_clr,
    input logic          err_opcode,
    input logic          err_cond,
    input logic          err_bus
);
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        used_cnt <= CW'(DEPTH));                                        // R3
    AST_VALID_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> used_cnt != '0);                                  // R2
    AST_DROP_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd_data[17] |-> push_rdy);                                 // R5
    AST_WAIT_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        !push_rdy |-> (used_cnt == CW'(DEPTH)) && !pop_ready);          // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_cause && !ovf_clr |=> ovf_cause);                           // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_data[16] |-> used_cnt == '0 && !pop_valid && push_rdy);  // R8
    AST_ERR_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (err_opcode || err_cond || err_bus) |=> cfg_rd_data[16]);       // R9
endmodule

bind cmd_queue iq_checker #(.DEPTH(DEPTH)) u_iq_checker (
    .clk         (clk),
    .rst         (rst),
    .cfg_rd_data (cfg_rd_data),
    .push_rdy    (push_rdy),
    .pop_valid   (pop_valid),
    .pop_ready   (pop_ready),
    .used_cnt    (used_cnt),
    .ovf_cause   (ovf_cause),
    .ovf_clr     (ovf_clr),
    .err_opcode  (err_opcode),
    .err_cond    (err_cond),
    .err_bus     (err_bus)
);

// File: tb/tb_cmd_queue.sv
module tb_cmd_queue;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        push_req = 1'b0;
    logic [31:0] push_data = '0;
    logic        push_rdy, pop_valid;
    logic [31:0] pop_data;
    logic        pop_ready = 1'b0;
    logic [3:0]  used_cnt;
    logic        level_evt, ovf_cause;
    logic        ovf_clr = 1'b0;
    logic        err_opcode = 1'b0, err_cond = 1'b0, err_bus = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // Reference model state
    logic [31:0] q[$];
    logic        m_stall = 1'b1, m_flush = 1'b0, m_ovf = 1'b0;
    logic [2:0]  m_lvl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_queue dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] m_cfg();
        return {14'b0, m_stall, m_flush, 13'b0, m_lvl};
    endfunction

    // Inputs are already driven (after a negedge); check, then advance one edge.
    task automatic step();
        int sz;
        logic fire, acc, oset;
        #1;
        sz = m_flush ? 0 : q.size();
        chk("R9", cfg_rd_data, m_cfg());
        chk(m_flush ? "R8" : "R3", 32'(used_cnt), 32'(sz));
        chk(m_flush ? "R8" : "R2", 32'(pop_valid), 32'(sz > 0));
        if (sz > 0) chk("R2", pop_data, q[0]);
        chk("R4", 32'(level_evt), 32'(sz < int'(m_lvl)));
        chk(m_flush ? "R8" : (m_stall ? "R6" : "R5"), 32'(push_rdy),
            32'(m_flush || !m_stall || sz < DEPTH || pop_ready));
        chk("R7", 32'(ovf_cause), 32'(m_ovf));
        fire = pop_ready && sz > 0;
        acc  = push_req && !m_flush && (sz < DEPTH || fire);
        oset = push_req && !m_flush && sz == DEPTH && !fire;
        @(posedge clk);
        if (m_flush) q.delete();
        else begin
            if (fire) void'(q.pop_front());
            if (acc)  q.push_back(push_data);
        end
        if (oset) m_ovf = 1'b1;
        else if (ovf_clr) m_ovf = 1'b0;
        if (cfg_wr_en) begin
            m_stall = cfg_wr_data[17];
            m_flush = cfg_wr_data[16];
            m_lvl   = cfg_wr_data[2:0];
        end
        if (err_opcode || err_cond || err_bus) m_flush = 1'b1;
        @(negedge clk);
        cfg_wr_en = 0; push_req = 0; pop_ready = 0; ovf_clr = 0;
        err_opcode = 0; err_cond = 0; err_bus = 0;
    endtask

    task automatic wcfg(input logic [31:0] v);
        cfg_wr_en = 1; cfg_wr_data = v; step();
    endtask

    task automatic push(input logic [31:0] d, input logic pr);
        push_req = 1; push_data = d; pop_ready = pr; step();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic hold;
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1", cfg_rd_data, 32'h0002_0000);
        chk("R1", 32'(used_cnt), 0);
        chk("R1", 32'(ovf_cause), 0);
        // R1 reserved bits read zero
        wcfg(32'hFFFF_FFFF);
        chk("R1", cfg_rd_data, 32'h0003_0007);
        wcfg(32'h0002_0000);

        // R6 stall mode: fill, hold a write, release by pop
        for (int i = 0; i < DEPTH; i++) push(32'hA000_0000 + i, 0);
        push(32'hBEEF_0001, 0);              // blocked, overflow R7
        chk("R6", 32'(push_rdy), 0);
        chk("R7", 32'(ovf_cause), 1);
        push(32'hBEEF_0001, 1);              // stored while head leaves R3
        chk("R3", 32'(used_cnt), 8);
        ovf_clr = 1; step();
        chk("R7", 32'(ovf_cause), 0);
        for (int i = 0; i < DEPTH; i++) begin pop_ready = 1; step(); end
        chk("R2", 32'(used_cnt), 0);

        // R5 drop mode
        wcfg(32'h0000_0000);
        for (int i = 0; i <= DEPTH; i++) push(32'hC000_0000 + i, 0);
        chk("R5", 32'(used_cnt), 8);
        chk("R5", pop_data, 32'hC000_0000);
        // R7 set beats clear in same cycle
        push_req = 1; push_data = 32'h1; ovf_clr = 1; step();
        chk("R7", 32'(ovf_cause), 1);

        // R8 held flush with traffic
        wcfg(32'h0001_0000);
        for (int i = 0; i < 4; i++) push(32'hD000_0000 + i, 1);
        chk("R8", 32'(used_cnt), 0);
        wcfg(32'h0002_0000);
        chk("R8", 32'(pop_valid), 0);

        // R4 every threshold at every occupancy
        for (int n = 0; n <= DEPTH; n++) begin
            wcfg(32'h0003_0000); wcfg(32'h0002_0000);
            for (int i = 0; i < n; i++) push(32'hE000_0000 + i, 0);
            for (int l = 0; l < 8; l++) wcfg(32'h0002_0000 | 32'(l));
        end

        // R9 each error over a concurrent write that clears flush
        for (int e = 0; e < 3; e++) begin
            push(32'hF0, 0);
            cfg_wr_en = 1; cfg_wr_data = 32'h0002_0005;
            err_opcode = (e == 0); err_cond = (e == 1); err_bus = (e == 2);
            step();
            chk("R9", 32'(cfg_rd_data[16]), 1);
            wcfg(32'h0002_0000);
        end

        // Random phase
        hold = 0;
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 3) begin
                cfg_wr_en = 1;
                cfg_wr_data = {14'b0, 1'($urandom), ($urandom_range(0, 9) == 0), 13'b0, 3'($urandom)};
            end
            if (r == 50) err_bus = 1;
            if (r == 51) err_opcode = 1;
            if (r == 52) err_cond = 1;
            if (r >= 90) ovf_clr = 1;
            if (!hold) begin
                push_req = ($urandom_range(0, 2) != 0);
                push_data = $urandom;
            end else push_req = 1;
            pop_ready = ($urandom_range(0, 2) == 0);
            #1;
            hold = push_req && !push_rdy;
            step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule